// File: doc/BRIEF.md
# Word-Mapped Bidirectional Pin Port

This block gives a processor an 8-pin general-purpose port through a single 20-bit register at one bus address. One write to that register sets two things at once. The low byte of the word becomes the output data latch. The byte at bits 17..10 becomes the per-pin direction mask. A direction bit of 1 makes its pin an output that drives the latched data bit. A direction bit of 0 releases the pin, which is then tristated and acts as an input.

A read of the same register returns the live pad levels, taken without a latch at the moment of the read, in the low byte. It returns the stored direction mask in bits 17..10. Bits 9..8 and 19..18 read as zero.

Pins may be mixed freely, for example four inputs and four outputs. An optional edge detector raises a one-cycle interrupt request when an input-configured pin rises, after a two-flop synchronizer. The register sits at numeric address 16BAAA. That value is the XOR of the bit-pattern address 1C1000 with AAAAA.

Top module: `gpio_word_port`

## Requirements
- R1: While reset is asserted and after it is released, pad_oe, pad_out and irq are 0 and a read returns 0 in bits 17..10, so every pin starts as an input with data 0.
- R2: A write (bus_sel=1, bus_we=1, bus_addr equal to PORT_ADDR, default 24'h16BAAA) stores bus_wdata[7:0] as the output data byte, visible on the pins from the next clock cycle.
- R3: The same write stores bus_wdata[17:10] as the direction byte, and pad_oe equals it from the next cycle. The word 3FC00 turns all pins into outputs, and 00000 turns them all into inputs.
- R4: pad_out[i] carries data bit i only when pad_oe[i] is 1 and is 0 otherwise.
- R5: A read (bus_sel=1, bus_we=0, matching address) returns, in the same cycle, pad_in in bits 7..0, 0 in bits 9..8, the direction byte in bits 17..10 and 0 in bits 19..18. bus_rdata is 0 whenever no matching read is present.
- R6: A write to any other address changes neither the data byte nor the direction byte.
- R7: Bits 9..8 and 19..18 of a write are ignored.
- R8: Each pin follows its own direction bit. With a mixed mask, the read's low byte shows the driven bits of the output pins and the external levels of the input pins.
- R9: A rising level on an input-configured pin raises irq for exactly one cycle. irq is high in the second cycle after the pad changes, once the level has passed two synchronizer flops.
- R10: A rising level on an output-configured pin raises no irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Numeric word address |
| bus_wdata | input | 20 | Write word |
| bus_rdata | output | 20 | Read word, combinational |
| pad_in | input | 8 | Level seen at each pad |
| pad_out | output | 8 | Value driven toward each pad |
| pad_oe | output | 8 | Per-pad output enable |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The read path is combinational, so read results are checked shortly after the strobe is applied, within the same cycle. A write takes effect at the next rising edge, so the data byte, the direction byte and pad_out are checked at the falling edge that follows that edge. The interrupt passes through two synchronizer flops. The bench changes a pad at a falling edge, expects irq low after the first rising edge, high after the second and low again after the third, and samples at each of those falling edges. The bench models the pad as its own driven value when the pin is enabled and an external level otherwise, which lets it compute readback values for mixed directions.

// File: rtl/gpio_word_pkg.sv
package gpio_word_pkg;
   // Direction encoding of one pin
   typedef enum logic {
      PIN_IN  = 1'b0,
      PIN_OUT = 1'b1
   } pin_dir_e;

   localparam int DEF_PIN_W   = 8;
   localparam int DEF_WORD_W  = 20;
   localparam int DEF_ADDR_W  = 24;
   localparam int DEF_DATA_LSB = 0;
   localparam int DEF_DIR_LSB  = 10;

   // Bit-pattern addresses differ from numeric ones by this constant.
   localparam logic [23:0] PATTERN_XOR = 24'h0AAAAA;
   localparam logic [23:0] PORT_PATTERN = 24'h1C1000;
   localparam logic [23:0] PORT_NUMERIC = PORT_PATTERN ^ PATTERN_XOR;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode #(
   parameter int          ADDR_W    = 24,
   parameter logic [ADDR_W-1:0] PORT_ADDR = '0
) (
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              wr_hit,
   output logic              rd_hit
);
   logic addr_match;

   always_comb begin
      addr_match = (bus_addr == PORT_ADDR);
      wr_hit     = bus_sel &  bus_we & addr_match;
      rd_hit     = bus_sel & ~bus_we & addr_match;
   end
endmodule

// File: rtl/gpio_pin_latch.sv
module gpio_pin_latch
   import gpio_word_pkg::*;
#(
   parameter int PIN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PIN_W-1:0] new_data,
   input  logic [PIN_W-1:0] new_dir,
   output logic [PIN_W-1:0] dir_q,
   output logic [PIN_W-1:0] pad_out,
   output logic [PIN_W-1:0] pad_oe
);
   for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      logic     data_bit_q;
      pin_dir_e mode_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_bit_q <= 1'b0;
            mode_q     <= PIN_IN;
         end else if (load) begin
            data_bit_q <= new_data[i];
            mode_q     <= pin_dir_e'(new_dir[i]);
         end
      end

      always_comb begin
         dir_q[i]   = (mode_q == PIN_OUT);
         pad_oe[i]  = (mode_q == PIN_OUT);
         pad_out[i] = (mode_q == PIN_OUT) ? data_bit_q : 1'b0;
      end
   end
endmodule

// File: rtl/gpio_read_format.sv
module gpio_read_format #(
   parameter int PIN_W    = 8,
   parameter int WORD_W   = 20,
   parameter int DATA_LSB = 0,
   parameter int DIR_LSB  = 10
) (
   input  logic              rd_hit,
   input  logic [PIN_W-1:0]  pad_lvl,
   input  logic [PIN_W-1:0]  dir_q,
   output logic [WORD_W-1:0] rdata
);
   localparam int DATA_MSB = DATA_LSB + PIN_W - 1;
   localparam int DIR_MSB  = DIR_LSB + PIN_W - 1;

   logic [WORD_W-1:0] word;

   for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      if (b >= DATA_LSB && b <= DATA_MSB) begin : g_pad
         assign word[b] = pad_lvl[b-DATA_LSB];
      end else if (b >= DIR_LSB && b <= DIR_MSB) begin : g_dir
         assign word[b] = dir_q[b-DIR_LSB];
      end else begin : g_zero
         assign word[b] = 1'b0;
      end
   end

   assign rdata = rd_hit ? word : '0;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
   parameter int PIN_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIN_W-1:0] pad_lvl,
   input  logic [PIN_W-1:0] dir_q,
   output logic             irq
);
   logic [SYNC_STAGES-1:0][PIN_W-1:0] sync_q;
   logic [PIN_W-1:0] prev_q;
   logic [PIN_W-1:0] rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= '0;
      end else begin
         sync_q[0] <= pad_lvl;
         for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   always_comb begin
      rise = sync_q[SYNC_STAGES-1] & ~prev_q & ~dir_q;
      irq  = |rise;
   end
endmodule

// File: rtl/gpio_word_port.sv
module gpio_word_port
   import gpio_word_pkg::*;
#(
   parameter int                PIN_W       = DEF_PIN_W,
   parameter int                WORD_W      = DEF_WORD_W,
   parameter int                ADDR_W      = DEF_ADDR_W,
   parameter int                DATA_LSB    = DEF_DATA_LSB,
   parameter int                DIR_LSB     = DEF_DIR_LSB,
   parameter logic [ADDR_W-1:0] PORT_ADDR   = ADDR_W'(PORT_NUMERIC),
   parameter bit                IRQ_EN      = 1'b1,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   input  logic [PIN_W-1:0]  pad_in,
   output logic [PIN_W-1:0]  pad_out,
   output logic [PIN_W-1:0]  pad_oe,
   output logic              irq
);
   localparam int DATA_MSB = DATA_LSB + PIN_W - 1;
   localparam int DIR_MSB  = DIR_LSB + PIN_W - 1;

   if (DATA_MSB >= WORD_W || DIR_MSB >= WORD_W) begin : g_bad_width
      $error("gpio_word_port: a field lies outside the word");
   end
   if (!(DATA_MSB < DIR_LSB || DIR_MSB < DATA_LSB)) begin : g_bad_overlap
      $error("gpio_word_port: data and direction fields overlap");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_word_port: at least two synchronizer stages required");
   end

   logic             wr_hit;
   logic             rd_hit;
   logic [PIN_W-1:0] dir_q;

   gpio_addr_decode #(
      .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)
   ) u_decode (
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .wr_hit(wr_hit), .rd_hit(rd_hit)
   );

   gpio_pin_latch #(.PIN_W(PIN_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .load(wr_hit),
      .new_data(bus_wdata[DATA_MSB:DATA_LSB]),
      .new_dir(bus_wdata[DIR_MSB:DIR_LSB]),
      .dir_q(dir_q), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   gpio_read_format #(
      .PIN_W(PIN_W), .WORD_W(WORD_W), .DATA_LSB(DATA_LSB), .DIR_LSB(DIR_LSB)
   ) u_rdfmt (
      .rd_hit(rd_hit), .pad_lvl(pad_in), .dir_q(dir_q), .rdata(bus_rdata)
   );

   if (IRQ_EN) begin : g_irq
      gpio_edge_irq #(.PIN_W(PIN_W), .SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk(clk), .rst_n(rst_n), .pad_lvl(pad_in), .dir_q(dir_q), .irq(irq)
      );
   end else begin : g_no_irq
      assign irq = 1'b0;
   end
endmodule

// File: rtl/gpio_word_port_chk.sv
module gpio_word_port_chk #(
   parameter int                PIN_W     = 8,
   parameter int                WORD_W    = 20,
   parameter int                ADDR_W    = 24,
   parameter int                DATA_LSB  = 0,
   parameter int                DIR_LSB   = 10,
   parameter logic [ADDR_W-1:0] PORT_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [WORD_W-1:0] bus_wdata,
   input logic [WORD_W-1:0] bus_rdata,
   input logic [PIN_W-1:0]  pad_in,
   input logic [PIN_W-1:0]  pad_out,
   input logic [PIN_W-1:0]  pad_oe,
   input logic              irq
);
   logic [WORD_W-1:0] field_mask;
   always_comb begin
      field_mask = '0;
      for (int k = 0; k < PIN_W; k++) begin
         field_mask[DATA_LSB+k] = 1'b1;
         field_mask[DIR_LSB+k]  = 1'b1;
      end
   end

   // R1: reset leaves every pin an input with no request
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (pad_oe == '0 && pad_out == '0 && !irq));

   // R3: enables follow the direction field of the last accepted write
   assert_oe_follows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && bus_addr == PORT_ADDR)
      |=> pad_oe == $past(bus_wdata[DIR_LSB +: PIN_W]));

   // R4: no drive on a released pin
   assert_out_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~pad_oe) == '0);

   // R5: readback shows live pads, enables and zero fill
   assert_read_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_addr == PORT_ADDR)
      |-> (bus_rdata[DATA_LSB +: PIN_W] == pad_in &&
           bus_rdata[DIR_LSB +: PIN_W] == pad_oe &&
           (bus_rdata & ~field_mask) == '0));

   // R5: nothing on the read bus without a matching read
   assert_read_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_we && bus_addr == PORT_ADDR) |-> bus_rdata == '0);

   // R6: writes elsewhere leave the pins alone
   assert_miss_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && bus_addr != PORT_ADDR)
      |=> ($stable(pad_oe) && $stable(pad_out)));

   // R7: driven data comes only from the data field
   assert_data_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && bus_addr == PORT_ADDR)
      |=> pad_out == ($past(bus_wdata[DATA_LSB +: PIN_W]) &
                      $past(bus_wdata[DIR_LSB +: PIN_W])));
endmodule

bind gpio_word_port gpio_word_port_chk #(
   .PIN_W(PIN_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
   .DATA_LSB(DATA_LSB), .DIR_LSB(DIR_LSB), .PORT_ADDR(PORT_ADDR)
) u_chk (.*);

// File: tb/gpio_word_port_bench.sv
module gpio_word_port_bench;
   localparam logic [23:0] ADDR = 24'h16BAAA;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [23:0] bus_addr = '0;
   logic [19:0] bus_wdata = '0;
   logic [19:0] bus_rdata;
   logic [7:0]  pad_in;
   logic [7:0]  pad_out;
   logic [7:0]  pad_oe;
   logic        irq;
   logic [7:0]  ext = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   // Pad model: an enabled pin shows its own drive, a released one the outside level
   assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

   gpio_word_port u_gpio_word_port (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [23:0] a, input logic [19:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
      #1;
   endtask

   task automatic bus_read(input logic [23:0] a, output logic [19:0] d);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
      #1;
   endtask

   task automatic t_reset;
      logic [19:0] r;
      check("R1 oe", 32'(pad_oe), 0);
      check("R1 out", 32'(pad_out), 0);
      check("R1 irq", 32'(irq), 0);
      bus_read(ADDR, r);
      check("R1 dir readback", 32'(r[17:10]), 0);
   endtask

   task automatic t_all_out;
      logic [19:0] r;
      bus_write(ADDR, 20'h3FC00 | 20'hA5);
      check("R3 all outputs", 32'(pad_oe), 32'hFF);
      check("R2 data byte", 32'(pad_out), 32'hA5);
      bus_read(ADDR, r);
      check("R5 readback", 32'(r), 32'h3FCA5);
      bus_read(ADDR ^ 24'h1, r);
      check("R5 read miss", 32'(r), 0);
   endtask

   task automatic t_mixed;
      logic [19:0] r;
      bus_write(ADDR, (20'h0F << 10) | 20'h3C);
      check("R3 mixed oe", 32'(pad_oe), 32'h0F);
      check("R4 masked out", 32'(pad_out), 32'h0C);
      ext = 8'hA5;
      #1;
      bus_read(ADDR, r);
      check("R8 mixed pads", 32'(r), 32'h03CAC);
   endtask

   task automatic t_miss;
      bus_write(ADDR ^ 24'h100, 20'h3FCFF);
      check("R6 oe kept", 32'(pad_oe), 32'h0F);
      check("R6 out kept", 32'(pad_out), 32'h0C);
   endtask

   task automatic t_reserved;
      logic [19:0] r;
      bus_write(ADDR, 20'hC0300 | (20'h33 << 10) | 20'h55);
      check("R7 oe", 32'(pad_oe), 32'h33);
      check("R7 out", 32'(pad_out), 32'h11);
      bus_read(ADDR, r);
      check("R7 zero fields", 32'(r & 20'hC0300), 0);
   endtask

   task automatic t_all_in;
      bus_write(ADDR, 20'h000FF);
      check("R3 all inputs", 32'(pad_oe), 0);
      check("R4 no drive", 32'(pad_out), 0);
   endtask

   task automatic t_irq_in;
      // pins 3..0 outputs (data 0), 7..4 inputs
      bus_write(ADDR, 20'h0F << 10);
      ext = 8'h00;
      repeat (4) @(negedge clk);
      ext = 8'h10;
      @(negedge clk); #1;
      check("R9 irq after one edge", 32'(irq), 0);
      @(negedge clk); #1;
      check("R9 irq after two edges", 32'(irq), 1);
      @(negedge clk); #1;
      check("R9 irq one cycle", 32'(irq), 0);
   endtask

   task automatic t_irq_out;
      int seen = 0;
      bus_write(ADDR, (20'h0F << 10) | 20'h01);
      for (int c = 0; c < 5; c++) begin
         @(negedge clk); #1;
         if (irq) seen++;
      end
      check("R10 no irq from output", 32'(seen), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset;
      rst_n = 1'b1;
      @(negedge clk); #1;
      t_reset;
      t_all_out;
      t_mixed;
      t_miss;
      t_reserved;
      t_all_in;
      t_irq_in;
      t_irq_out;
      done = 1'b1;
   end

   initial begin
      for (int w = 0; w < 5000; w++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule